// File: doc/BRIEF.md
# PCM Highway Time-Slot Interface

This block connects one voice channel to a time-division PCM highway. It runs on the highway bit clock. A frame sync marks the start of every frame, and the block counts bit positions from it. In its programmed transmit slot it shifts a stored sample out onto the highway. In its programmed receive slot it shifts a sample in from the highway. A frame may hold from 2 to 128 slots of 8 bits, which matches bit clocks from 128 kHz to 8.192 MHz at an 8 kHz frame rate.

Three sample formats are supported. The first is an 8-bit companded sample in one slot. The second is an 8-bit companded sample followed in the next slot by a signalling byte, and it applies to transmit only. The third is a 16-bit linear sample spread over two adjacent slots. Several configuration inputs set the behaviour: a start-of-frame bit delay of 0 to 7 clocks, and whether the transmit line changes on the rising or the falling clock edge. The transmit side has a data-out enable, so the line can be shared with other devices. The receive side gives a one-cycle strobe with each new sample.

Frame timing is held by a three-state machine. FR_IDLE waits for a sync. FR_ALIGN counts down the programmed bit delay. FR_RUN counts bit positions.

The transitions are:
- A detected sync moves any state to FR_ALIGN, or straight to FR_RUN with the bit counter cleared when the delay is 0.
- FR_ALIGN moves to FR_RUN once the delay count reaches zero.
- FR_RUN moves to FR_IDLE when the counter reaches the last bit of a 128-slot frame and no sync has arrived.

Top module: `pcm_tsi`

## Requirements
- R1: After reset, and until the first frame sync, tx_oe and txd are 0, rx_strobe is 0 and rx_sample is 0.
- R2: fsync is sampled on the falling clock edge. The first rising edge that sees the sampled value newly high is edge E. Bit 0 of slot 0 occupies the clock cycle that follows rising edge E + cfg_bit_off, and each later bit takes one more cycle.
- R3: With cfg_mode 2'b00 (and the reserved code 2'b11, which acts the same), tx_sample[7:0] is sent most-significant bit first in the 8 bits of slot cfg_tx_slot.
- R4: With cfg_mode 2'b01, tx_sample[7:0] is sent in slot cfg_tx_slot and then tx_sig is sent in slot cfg_tx_slot+1, both most-significant bit first.
- R5: With cfg_mode 2'b10, tx_sample is sent over slots cfg_tx_slot and cfg_tx_slot+1 as 16 bits, most-significant bit first. The high byte therefore goes in the first slot.
- R6: tx_oe is 1 only during the bits of the channel's own transmit slots. Whenever tx_oe is 0, txd is 0.
- R7: With cfg_tx_fall 0, txd and tx_oe change just after the rising edge that starts a bit. With cfg_tx_fall 1, they change on the following falling edge, half a cycle later.
- R8: With cfg_mode other than 2'b10, the receive sample is 8 bits, most-significant bit first, from slot cfg_rx_slot. It is taken on the rising edge that ends each bit. rx_sample becomes {8'h00, byte}, and rx_strobe is high for the single cycle after the last bit is captured.
- R9: With cfg_mode 2'b10, the receive sample is 16 bits from slots cfg_rx_slot and cfg_rx_slot+1, with the first bit received as bit 15. rx_strobe follows the same timing as in R8.
- R10: tx_sample and tx_sig are latched at edge E. Changes to them after that edge have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync |
| rxd | input | 1 | Highway receive data |
| txd | output | 1 | Highway transmit data |
| tx_oe | output | 1 | Transmit drive enable; the line is high-impedance when this is 0 |
| tx_sample | input | 16 | Sample to send; only the low byte is used in the companded modes |
| tx_sig | input | 8 | Signalling byte for mode 2'b01 |
| rx_sample | output | 16 | Last received sample |
| rx_strobe | output | 1 | One-cycle pulse when a new receive sample is ready |
| cfg_tx_slot | input | 7 | Transmit slot number |
| cfg_rx_slot | input | 7 | Receive slot number |
| cfg_mode | input | 2 | Sample format: 00 companded, 01 companded plus signalling, 10 linear, 11 treated as 00 |
| cfg_bit_off | input | 3 | Bit delay from the frame sync to bit 0 |
| cfg_tx_fall | input | 1 | 1 launches transmit data on the falling edge |

## Verification
Directed frames cover each format with the bit delay at 0 and at 7, and with the slot at the first position and at the highest tested position. Off-by-one errors in the delay count or the slot base show up as shifted bit patterns. Random frames then vary the format, both slot numbers, the delay, the launch edge and the data, while the receive line carries random noise outside the receive slot. This shows whether the shift windows are bounded correctly.

Every bit is sampled at two points in the clock cycle, so the two launch edges give different expected values. The sample inputs are also changed right after each sync, which separates latching at the frame start from reading the live inputs.

// File: rtl/pcm_tsi_pkg.sv
package pcm_tsi_pkg;
    typedef enum logic [1:0] {
        MODE_COMP     = 2'b00,
        MODE_COMP_SIG = 2'b01,
        MODE_LIN      = 2'b10,
        MODE_RSVD     = 2'b11
    } smode_t;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_ALIGN,
        FR_RUN
    } fstate_t;

    function automatic logic is_two_slot_tx(smode_t m);
        return (m == MODE_COMP_SIG) || (m == MODE_LIN);
    endfunction
endpackage

// File: rtl/pcm_tsi_frame.sv
module pcm_tsi_frame
    import pcm_tsi_pkg::*;
#(
    parameter int MAX_SLOTS = 128,
    localparam int BIT_W = $clog2(MAX_SLOTS) + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic [2:0]       bit_off,
    output logic             run,
    output logic [BIT_W-1:0] bit_cnt,
    output logic             frame_start
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(MAX_SLOTS * 8 - 1);

    logic             fs_neg;
    logic             fs_seen;
    logic             sync_det;
    fstate_t          state, state_nx;
    logic [2:0]       skip, skip_nx;
    logic [BIT_W-1:0] cnt, cnt_nx;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fs_neg <= 1'b0;
        else        fs_neg <= fsync;
    end

    assign sync_det = fs_neg & ~fs_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_seen <= 1'b0;
            state   <= FR_IDLE;
            skip    <= '0;
            cnt     <= '0;
        end else begin
            fs_seen <= fs_neg;
            state   <= state_nx;
            skip    <= skip_nx;
            cnt     <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        skip_nx  = skip;
        cnt_nx   = cnt;
        if (sync_det) begin
            if (bit_off == 3'd0) begin
                state_nx = FR_RUN;
                cnt_nx   = '0;
            end else begin
                state_nx = FR_ALIGN;
                skip_nx  = bit_off - 3'd1;
            end
        end else begin
            unique case (state)
                FR_IDLE: begin
                    state_nx = FR_IDLE;
                end
                FR_ALIGN: begin
                    if (skip == 3'd0) begin
                        state_nx = FR_RUN;
                        cnt_nx   = '0;
                    end else begin
                        skip_nx = skip - 3'd1;
                    end
                end
                FR_RUN: begin
                    if (cnt == LAST_BIT) state_nx = FR_IDLE;
                    else                 cnt_nx   = cnt + 1'b1;
                end
                default: state_nx = FR_IDLE;
            endcase
        end
    end

    always_comb begin
        run         = (state == FR_RUN);
        bit_cnt     = cnt;
        frame_start = sync_det;
    end

    // R2: the delay count never exceeds six once loaded
    p_align_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_ALIGN) |-> (skip < 3'd7));

    // R2: a sync with zero delay starts bit 0 on the next cycle
    p_run_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_det && bit_off == 3'd0) |=> (run && bit_cnt == '0));

    // R2: bit positions advance by one per clock
    p_run_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sync_det && bit_cnt != LAST_BIT) |=> (run && bit_cnt == $past(bit_cnt) + 1'b1));
endmodule

// File: rtl/pcm_tsi_tx.sv
module pcm_tsi_tx
    import pcm_tsi_pkg::*;
#(
    parameter int MAX_SLOTS = 128,
    localparam int SLOT_W = $clog2(MAX_SLOTS),
    localparam int BIT_W = SLOT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BIT_W-1:0]  bit_cnt,
    input  logic              frame_start,
    input  logic [SLOT_W-1:0] tx_slot,
    input  smode_t            mode,
    input  logic              tx_fall,
    input  logic [15:0]       tx_sample,
    input  logic [7:0]        tx_sig,
    output logic              txd,
    output logic              tx_oe
);
    logic [15:0]      word;
    logic [BIT_W-1:0] win_pos;
    logic [BIT_W-1:0] win_len;
    logic             oe_rise, d_rise;
    logic             oe_fall, d_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           word <= '0;
        else if (frame_start) word <= (mode == MODE_LIN) ? tx_sample : {tx_sample[7:0], tx_sig};
    end

    always_comb begin
        win_pos = bit_cnt - {tx_slot, 3'b000};
        win_len = is_two_slot_tx(mode) ? BIT_W'(16) : BIT_W'(8);
        oe_rise = run && (win_pos < win_len);
        d_rise  = oe_rise && word[4'd15 - win_pos[3:0]];
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_fall <= 1'b0;
            d_fall  <= 1'b0;
        end else begin
            oe_fall <= oe_rise;
            d_fall  <= d_rise;
        end
    end

    always_comb begin
        tx_oe = tx_fall ? oe_fall : oe_rise;
        txd   = tx_fall ? d_fall  : d_rise;
    end

    // R6: the rising-edge drive enable only appears while bits are counted
    p_oe_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_rise |-> run);

    // R6: the line carries no data while not driven
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !txd);
endmodule

// File: rtl/pcm_tsi_rx.sv
module pcm_tsi_rx
    import pcm_tsi_pkg::*;
#(
    parameter int MAX_SLOTS = 128,
    localparam int SLOT_W = $clog2(MAX_SLOTS),
    localparam int BIT_W = SLOT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BIT_W-1:0]  bit_cnt,
    input  logic [SLOT_W-1:0] rx_slot,
    input  smode_t            mode,
    input  logic              rxd,
    output logic [15:0]       rx_sample,
    output logic              rx_strobe
);
    logic [15:0]      sr;
    logic [BIT_W-1:0] win_pos;
    logic [BIT_W-1:0] win_len;
    logic             in_win;

    always_comb begin
        win_pos = bit_cnt - {rx_slot, 3'b000};
        win_len = (mode == MODE_LIN) ? BIT_W'(16) : BIT_W'(8);
        in_win  = run && (win_pos < win_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr        <= '0;
            rx_sample <= '0;
            rx_strobe <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            if (in_win) begin
                sr <= {sr[14:0], rxd};
                if (win_pos == win_len - 1'b1) begin
                    rx_sample <= (mode == MODE_LIN) ? {sr[14:0], rxd} : {8'h00, sr[6:0], rxd};
                    rx_strobe <= 1'b1;
                end
            end
        end
    end

    // R8: the strobe lasts one cycle
    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);

    // R8: a strobe follows a cycle with bits being counted
    p_strobe_from_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_strobe) |-> $past(run));
endmodule

// File: rtl/pcm_tsi.sv
module pcm_tsi
    import pcm_tsi_pkg::*;
#(
    parameter int MAX_SLOTS = 128,
    localparam int SLOT_W = $clog2(MAX_SLOTS),
    localparam int BIT_W = SLOT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              rxd,
    output logic              txd,
    output logic              tx_oe,
    input  logic [15:0]       tx_sample,
    input  logic [7:0]        tx_sig,
    output logic [15:0]       rx_sample,
    output logic              rx_strobe,
    input  logic [SLOT_W-1:0] cfg_tx_slot,
    input  logic [SLOT_W-1:0] cfg_rx_slot,
    input  logic [1:0]        cfg_mode,
    input  logic [2:0]        cfg_bit_off,
    input  logic              cfg_tx_fall
);
    logic             run;
    logic [BIT_W-1:0] bit_cnt;
    logic             frame_start;
    smode_t           mode;

    assign mode = smode_t'(cfg_mode);

    pcm_tsi_frame #(.MAX_SLOTS(MAX_SLOTS)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsync       (fsync),
        .bit_off     (cfg_bit_off),
        .run         (run),
        .bit_cnt     (bit_cnt),
        .frame_start (frame_start)
    );

    pcm_tsi_tx #(.MAX_SLOTS(MAX_SLOTS)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .bit_cnt     (bit_cnt),
        .frame_start (frame_start),
        .tx_slot     (cfg_tx_slot),
        .mode        (mode),
        .tx_fall     (cfg_tx_fall),
        .tx_sample   (tx_sample),
        .tx_sig      (tx_sig),
        .txd         (txd),
        .tx_oe       (tx_oe)
    );

    pcm_tsi_rx #(.MAX_SLOTS(MAX_SLOTS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .bit_cnt   (bit_cnt),
        .rx_slot   (cfg_rx_slot),
        .mode      (mode),
        .rxd       (rxd),
        .rx_sample (rx_sample),
        .rx_strobe (rx_strobe)
    );
endmodule

// File: tb/pcm_tsi_tb.sv
module pcm_tsi_tb;
    localparam int NB = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fsync;
    logic        rxd;
    logic        txd;
    logic        tx_oe;
    logic [15:0] tx_sample;
    logic [7:0]  tx_sig;
    logic [15:0] rx_sample;
    logic        rx_strobe;
    logic [6:0]  cfg_tx_slot;
    logic [6:0]  cfg_rx_slot;
    logic [1:0]  cfg_mode;
    logic [2:0]  cfg_bit_off;
    logic        cfg_tx_fall;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pcm_tsi u_dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .rxd(rxd), .txd(txd), .tx_oe(tx_oe),
        .tx_sample(tx_sample), .tx_sig(tx_sig), .rx_sample(rx_sample), .rx_strobe(rx_strobe),
        .cfg_tx_slot(cfg_tx_slot), .cfg_rx_slot(cfg_rx_slot), .cfg_mode(cfg_mode),
        .cfg_bit_off(cfg_bit_off), .cfg_tx_fall(cfg_tx_fall)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // returns {oe, data} expected for bit position b of the frame
    function automatic logic [1:0] exp_tx(int b, int mode, int slot, logic [15:0] s, logic [7:0] g);
        int len;
        int w;
        logic [15:0] word;
        len  = (mode == 1 || mode == 2) ? 16 : 8;
        w    = b - slot * 8;
        word = (mode == 2) ? s : {s[7:0], g};
        if (b < 0 || w < 0 || w >= len) return 2'b00;
        return {1'b1, word[15 - w]};
    endfunction

    function automatic string tx_tag(int mode);
        if (mode == 1) return "R4/R6/R10";
        if (mode == 2) return "R5/R6/R10";
        return "R3/R6/R10";
    endfunction

    task automatic run_frame(input int mode, input int txs, input int rxs, input int off, input bit fall);
        logic [15:0] s;
        logic [15:0] rw;
        logic [7:0]  g;
        logic [1:0]  e;
        logic [15:0] rexp;
        int rlen;
        int rbase;
        int w;
        bit sexp;
        cfg_mode    = 2'(mode);
        cfg_tx_slot = 7'(txs);
        cfg_rx_slot = 7'(rxs);
        cfg_bit_off = 3'(off);
        cfg_tx_fall = fall;
        s  = 16'($urandom);
        g  = 8'($urandom);
        rw = 16'($urandom);
        tx_sample = s;
        tx_sig    = g;
        rlen  = (mode == 2) ? 16 : 8;
        rbase = rxs * 8;
        rexp  = (mode == 2) ? rw : {8'h00, rw[15:8]};
        @(posedge clk); #1 fsync = 1'b1;
        @(posedge clk); #1 fsync = 1'b0;
        // R10: live inputs change after edge E; the frame must use the old values
        tx_sample = ~s;
        tx_sig    = ~g;
        repeat (off) begin @(posedge clk); #1; end
        for (int b = 0; b < NB; b++) begin
            w = b - rbase;
            rxd = (w >= 0 && w < rlen) ? rw[15 - w] : 1'($urandom);
            #2;
            e = exp_tx(fall ? b - 1 : b, mode, txs, s, g);
            chk({tx_oe, txd} == e, "R7 early sample", {30'd0, tx_oe, txd}, {30'd0, e});
            #4;
            e = exp_tx(b, mode, txs, s, g);
            chk({tx_oe, txd} == e, tx_tag(mode), {30'd0, tx_oe, txd}, {30'd0, e});
            sexp = (b == rbase + rlen);
            chk(rx_strobe == sexp, (mode == 2) ? "R9 strobe" : "R8 strobe", {31'd0, rx_strobe}, {31'd0, sexp});
            if (sexp)
                chk(rx_sample == rexp, (mode == 2) ? "R9 sample" : "R8 sample", {16'd0, rx_sample}, {16'd0, rexp});
            @(posedge clk); #1;
        end
        repeat (2) begin @(posedge clk); #1; end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; fsync = 1'b0; rxd = 1'b0;
        tx_sample = 16'hA5C3; tx_sig = 8'h5A;
        cfg_tx_slot = '0; cfg_rx_slot = '0; cfg_mode = 2'b00; cfg_bit_off = '0; cfg_tx_fall = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state and no activity without a sync
        for (int i = 0; i < 10; i++) begin
            rxd = 1'($urandom);
            #6;
            chk(tx_oe == 1'b0 && txd == 1'b0, "R1 tx idle", {30'd0, tx_oe, txd}, 32'd0);
            chk(rx_strobe == 1'b0, "R1 strobe", {31'd0, rx_strobe}, 32'd0);
            chk(rx_sample == 16'd0, "R1 sample", {16'd0, rx_sample}, 32'd0);
            @(posedge clk); #1;
        end
        // R2: directed bit delays at both ends with each format and edge
        run_frame(0, 0, 0, 0, 1'b0);
        run_frame(0, 6, 5, 7, 1'b0);
        run_frame(1, 0, 5, 0, 1'b1);
        run_frame(1, 6, 0, 7, 1'b0);
        run_frame(2, 0, 0, 7, 1'b1);
        run_frame(2, 6, 5, 0, 1'b0);
        run_frame(3, 3, 2, 3, 1'b1);
        run_frame(2, 3, 3, 1, 1'b1);
        for (int k = 0; k < 40; k++)
            run_frame(int'($urandom % 4), int'($urandom % 7), int'($urandom % 6),
                      int'($urandom % 8), 1'($urandom));
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule